// File: doc/BRIEF.md
# DMA Channel Request and Address Sequencer

This block is the control core of one DMA channel. It chooses when the channel asks for the bus and steps the destination address after every completed transfer. It also counts the transfers still to go. Moving the data, handling the source address and raising interrupts belong to other blocks. The bus is modelled here as a request, a grant and a one-cycle acknowledge for each transfer.

A 9-bit control word holds the channel settings. Bit 8 is the channel enable. Bit 7 selects the transfer size (0 byte, 1 word). Bit 6 is the address direction (0 up, 1 down). Bit 5 enables address stepping. Bit 4 is a spare bit that is only stored. Bits 3..0 hold the trigger code. The trigger codes are 4'b0010 (falling edge on the active-low request pin), 4'b0011 (request pin held low), 4'b0110 (internal auto-request, one transfer per bus tenure) and 4'b0111 (internal auto-request that keeps the bus until the count is used up). Every other code is inert.

A transfer completes in a cycle where `bus_req`, `bus_grant` and `xfer_ack` are all high. The request pin passes through a two-flop synchroniser before the block uses it.

Top module: `dma_chan_seq`

## Requirements
- R1: While ctrl bit 5 is 0, a completed transfer leaves `dst_addr` unchanged, whatever ctrl bit 6 holds.
- R2: While ctrl bit 5 is 1, a completed transfer raises `dst_addr` by one step when ctrl bit 6 is 0 and lowers it by one step when ctrl bit 6 is 1. The address wraps modulo 2^ADDR_W.
- R3: The step is 1 when ctrl bit 7 is 0 (byte) and 2 when ctrl bit 7 is 1 (word).
- R4: After reset, `ctrl_rdata` is 0 (channel disabled, address fixed), and `bus_req`, `dst_addr`, `xfer_cnt` and `done_pulse` are 0.
- R5: With code 4'b0010, each falling edge of `ext_req_n` leads to exactly one transfer. Holding the pin low starts no further transfers.
- R6: With code 4'b0011, the channel requests the bus while the synchronised pin is low. It drops `bus_req` for at least one cycle after every transfer. It drops `bus_req` no later than four cycles after the pin goes high.
- R7: With code 4'b0110, `bus_req` is low in the cycle after each completed transfer and is raised again afterwards while transfers remain.
- R8: With code 4'b0111, `bus_req` stays high from one transfer to the next until the count runs out.
- R9: Ctrl bit 4 reads back the value last written to it and has no effect on operation.
- R10: Any trigger code other than the four listed above never raises `bus_req` and leaves `xfer_cnt` unchanged.
- R11: Each completed transfer decrements `xfer_cnt`. The transfer that brings it to 0 clears ctrl bit 8 and pulses `done_pulse` high for one cycle. A channel with a count of 0 never requests the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 9 | Control word to write |
| ctrl_rdata | output | 9 | Current control word |
| dst_we | input | 1 | Load strobe for the destination address |
| dst_wdata | input | ADDR_W | Destination address to load |
| cnt_we | input | 1 | Load strobe for the transfer count |
| cnt_wdata | input | CNT_W | Transfer count to load |
| ext_req_n | input | 1 | Active-low external request pin, asynchronous |
| bus_req | output | 1 | Bus request |
| bus_grant | input | 1 | Bus grant |
| xfer_ack | input | 1 | One-cycle pulse marking a finished transfer |
| dst_addr | output | ADDR_W | Current destination address |
| xfer_cnt | output | CNT_W | Transfers remaining |
| xfer_word | output | 1 | Size of the current transfer (1 = word) |
| done_pulse | output | 1 | One-cycle pulse when the count reaches 0 |

## Verification
The properties assume that `xfer_ack` is meaningful only while `bus_req` and `bus_grant` are both high. They also assume that software does not reload the address, the count or the control word in the same cycle as a completed transfer it is checking. The bench keeps `bus_grant` high and pulses `xfer_ack` only after it sees `bus_req` high at a falling clock edge. It performs every register write while the channel is disabled or waiting, never in an acknowledge cycle. It changes the request pin only at falling edges and holds each level for several cycles, so each edge passes cleanly through the synchroniser.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int CTRL_W = 9;

    localparam logic [3:0] CODE_PIN_EDGE  = 4'b0010;
    localparam logic [3:0] CODE_PIN_LEVEL = 4'b0011;
    localparam logic [3:0] CODE_AUTO_ONE  = 4'b0110;
    localparam logic [3:0] CODE_AUTO_RUN  = 4'b0111;

    typedef struct packed {
        logic       en;
        logic       word;
        logic       down;
        logic       step_en;
        logic       spare;
        logic [3:0] code;
    } ctrl_t;

    typedef enum logic [2:0] {
        TRIG_NONE,
        TRIG_EDGE,
        TRIG_LEVEL,
        TRIG_STEAL,
        TRIG_BURST
    } trig_e;

endpackage

// File: rtl/dma_src_decode.sv
module dma_src_decode
    import dma_seq_pkg::*;
(
    input  logic [3:0] code,
    output trig_e      kind
);
    always_comb begin
        case (code)
            CODE_PIN_EDGE:  kind = TRIG_EDGE;
            CODE_PIN_LEVEL: kind = TRIG_LEVEL;
            CODE_AUTO_ONE:  kind = TRIG_STEAL;
            CODE_AUTO_RUN:  kind = TRIG_BURST;
            default:        kind = TRIG_NONE;
        endcase
    end
endmodule

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic lvl,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], pin_n};
        s_d.prev  = s_q.chain[STAGES-1];
        lvl       = s_q.chain[STAGES-1];
        fall      = s_q.prev & ~s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              word,
    input  logic              down,
    input  logic              step_en,
    output logic [ADDR_W-1:0] next
);
    logic [ADDR_W-1:0] delta;

    always_comb begin
        delta = word ? ADDR_W'(2) : ADDR_W'(1);
        if (!step_en)  next = addr;
        else if (down) next = addr - delta;
        else           next = addr + delta;
    end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [8:0]        ctrl_wdata,
    output logic [8:0]        ctrl_rdata,
    input  logic              dst_we,
    input  logic [ADDR_W-1:0] dst_wdata,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              ext_req_n,
    output logic              bus_req,
    input  logic              bus_grant,
    input  logic              xfer_ack,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  xfer_cnt,
    output logic              xfer_word,
    output logic              done_pulse
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic              pend;
        logic              req;
        logic              done;
    } state_t;

    state_t            s_d, s_q;
    trig_e             kind;
    logic              pin_lvl;
    logic              pin_fall;
    logic              xfer_fire;
    logic              want;
    logic [ADDR_W-1:0] dst_next;

    dma_src_decode dec_i (
        .code (s_q.ctrl.code),
        .kind (kind)
    );

    dma_req_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (ext_req_n),
        .lvl   (pin_lvl),
        .fall  (pin_fall)
    );

    dma_addr_step #(.ADDR_W(ADDR_W)) step_i (
        .addr    (s_q.dst),
        .word    (s_q.ctrl.word),
        .down    (s_q.ctrl.down),
        .step_en (s_q.ctrl.step_en),
        .next    (dst_next)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        xfer_fire = s_q.req & bus_grant & xfer_ack;

        case (kind)
            TRIG_EDGE:  want = s_q.pend;
            TRIG_LEVEL: want = ~pin_lvl;
            TRIG_STEAL: want = 1'b1;
            TRIG_BURST: want = 1'b1;
            default:    want = 1'b0;
        endcase
        want = want & s_q.ctrl.en & (s_q.cnt != '0);

        // Edge-mode pending flag: cleared by a finished transfer, set by a new edge.
        if (xfer_fire) s_d.pend = 1'b0;
        if (pin_fall && kind == TRIG_EDGE && s_q.ctrl.en) s_d.pend = 1'b1;
        if (kind != TRIG_EDGE || !s_q.ctrl.en) s_d.pend = 1'b0;

        if (xfer_fire) begin
            s_d.dst = dst_next;
            s_d.cnt = s_q.cnt - CNT_ONE;
            s_d.req = (kind == TRIG_BURST) && s_q.ctrl.en && (s_q.cnt > CNT_ONE);
            if (s_q.cnt == CNT_ONE) begin
                s_d.ctrl.en = 1'b0;
                s_d.done    = 1'b1;
            end
        end else begin
            s_d.req = want;
        end

        if (ctrl_we) s_d.ctrl = ctrl_t'(ctrl_wdata);
        if (dst_we)  s_d.dst  = dst_wdata;
        if (cnt_we)  s_d.cnt  = cnt_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl_rdata = s_q.ctrl;
    assign bus_req    = s_q.req;
    assign dst_addr   = s_q.dst;
    assign xfer_cnt   = s_q.cnt;
    assign xfer_word  = s_q.ctrl.word;
    assign done_pulse = s_q.done;
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_we,
    input logic [8:0]        ctrl_rdata,
    input logic              dst_we,
    input logic              cnt_we,
    input logic              bus_req,
    input logic [ADDR_W-1:0] dst_addr,
    input logic [CNT_W-1:0]  xfer_cnt,
    input logic              done_pulse,
    input logic              xfer_fire,
    input logic              pin_lvl,
    input trig_e             kind
);
    logic [ADDR_W-1:0] step;
    assign step = ctrl_rdata[7] ? ADDR_W'(2) : ADDR_W'(1); // R3

    p_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_fire && !ctrl_rdata[5] && !dst_we && !ctrl_we) |=> $stable(dst_addr));

    p_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_fire && ctrl_rdata[5] && !ctrl_rdata[6] && !dst_we && !ctrl_we)
        |=> dst_addr == $past(dst_addr) + $past(step));

    p_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_fire && ctrl_rdata[5] && ctrl_rdata[6] && !dst_we && !ctrl_we)
        |=> dst_addr == $past(dst_addr) - $past(step));

    p_level_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == TRIG_LEVEL && pin_lvl && !xfer_fire) |=> !bus_req);

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_fire && kind != TRIG_BURST) |=> !bus_req);

    p_burst_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_fire && kind == TRIG_BURST && ctrl_rdata[8] && xfer_cnt > CNT_W'(1) && !ctrl_we)
        |=> bus_req);

    p_inert_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == TRIG_NONE && !xfer_fire) |=> !bus_req);

    p_last_xfer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_fire && xfer_cnt == CNT_W'(1) && !ctrl_we && !cnt_we)
        |=> (done_pulse && !ctrl_rdata[8] && xfer_cnt == '0));

    p_done_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> $past(xfer_fire));
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_rdata (ctrl_rdata),
    .dst_we     (dst_we),
    .cnt_we     (cnt_we),
    .bus_req    (bus_req),
    .dst_addr   (dst_addr),
    .xfer_cnt   (xfer_cnt),
    .done_pulse (done_pulse),
    .xfer_fire  (xfer_fire),
    .pin_lvl    (pin_lvl),
    .kind       (kind)
);

// File: tb/dma_chan_seq_tb_top.sv
module dma_chan_seq_tb_top;
    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctrl_we = 1'b0;
    logic [8:0]    ctrl_wdata = '0;
    logic [8:0]    ctrl_rdata;
    logic          dst_we = 1'b0;
    logic [AW-1:0] dst_wdata = '0;
    logic          cnt_we = 1'b0;
    logic [CW-1:0] cnt_wdata = '0;
    logic          ext_req_n = 1'b1;
    logic          bus_req;
    logic          bus_grant = 1'b1;
    logic          xfer_ack = 1'b0;
    logic [AW-1:0] dst_addr;
    logic [CW-1:0] xfer_cnt;
    logic          xfer_word;
    logic          done_pulse;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    dma_chan_seq #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .dst_we(dst_we), .dst_wdata(dst_wdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .ext_req_n(ext_req_n), .bus_req(bus_req), .bus_grant(bus_grant),
        .xfer_ack(xfer_ack), .dst_addr(dst_addr), .xfer_cnt(xfer_cnt),
        .xfer_word(xfer_word), .done_pulse(done_pulse)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [8:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic wr_dst(input logic [AW-1:0] v);
        @(negedge clk); dst_we = 1'b1; dst_wdata = v;
        @(negedge clk); dst_we = 1'b0;
    endtask

    task automatic wr_cnt(input logic [CW-1:0] v);
        @(negedge clk); cnt_we = 1'b1; cnt_wdata = v;
        @(negedge clk); cnt_we = 1'b0;
    endtask

    // Waits for a request, acknowledges one transfer, returns at the negedge after it completes.
    task automatic xfer(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 30 && !seen; i++) begin
            @(negedge clk);
            if (bus_req) seen = 1'b1;
        end
        if (seen) begin
            xfer_ack = 1'b1;
            @(negedge clk);
            xfer_ack = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit seen;
        int bad;
        longint exp_a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 reset state
        chk(ctrl_rdata == 9'h000, "R4 ctrl", ctrl_rdata, 0);
        chk(bus_req == 1'b0, "R4 req", bus_req, 0);
        chk(dst_addr == '0 && xfer_cnt == '0 && done_pulse == 1'b0, "R4 addr/cnt", dst_addr, 0);

        // Address mode sweep in single-transfer auto mode: R1 R2 R3 R7 R11
        for (int sz = 0; sz < 2; sz++) begin
            for (int m = 0; m < 4; m++) begin
                logic dn, se;
                int st;
                dn = m[1]; se = m[0]; st = sz ? 2 : 1;
                wr_cnt(16'd3);
                wr_dst(16'h0100);
                wr_ctrl({1'b1, 1'(sz), dn, se, 1'b0, 4'b0110});
                chk(xfer_word == 1'(sz), "R3 size out", xfer_word, sz);
                for (int k = 1; k <= 3; k++) begin
                    xfer(seen);
                    chk(seen, "R7 request", seen, 1);
                    exp_a = !se ? 64'h100 : (dn ? 64'h100 - k*st : 64'h100 + k*st);
                    chk(dst_addr == AW'(exp_a), se ? "R2 R3 step" : "R1 fixed", dst_addr, exp_a);
                    chk(xfer_cnt == CW'(3 - k), "R11 count", xfer_cnt, 3 - k);
                    if (k < 3) chk(bus_req == 1'b0, "R7 release", bus_req, 0);
                end
                chk(done_pulse == 1'b1, "R11 done pulse", done_pulse, 1);
                chk(ctrl_rdata[8] == 1'b0, "R11 enable cleared", ctrl_rdata[8], 0);
                @(negedge clk);
                chk(done_pulse == 1'b0, "R11 pulse width", done_pulse, 0);
            end
        end

        // R2 wrap: word decrement from 0
        wr_cnt(16'd1); wr_dst(16'h0000);
        wr_ctrl({1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'b0110});
        xfer(seen);
        chk(dst_addr == 16'hFFFE, "R2 wrap", dst_addr, 16'hFFFE);

        // R8 burst holds the bus
        wr_cnt(16'd4); wr_dst(16'h0200);
        wr_ctrl({1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0111});
        for (int k = 1; k <= 4; k++) begin
            xfer(seen);
            chk(bus_req == (k < 4), "R8 hold", bus_req, k < 4);
        end
        chk(dst_addr == 16'h0204, "R8 addr", dst_addr, 16'h0204);

        // R11 zero count never requests
        wr_cnt(16'd0);
        wr_ctrl({1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0111});
        bad = 0;
        repeat (6) begin @(negedge clk); if (bus_req) bad++; end
        chk(bad == 0, "R11 zero count", bad, 0);
        wr_ctrl(9'h000);

        // R10 inert codes with pin held low
        ext_req_n = 1'b0;
        for (int c = 0; c < 16; c++) begin
            if (c == 2 || c == 3 || c == 6 || c == 7) continue;
            wr_cnt(16'd2);
            wr_ctrl({1'b1, 4'b0000, 4'(c)});
            bad = 0;
            repeat (6) begin @(negedge clk); if (bus_req) bad++; end
            chk(bad == 0, "R10 inert code req", bad, 0);
            chk(xfer_cnt == 16'd2, "R10 count kept", xfer_cnt, 2);
        end
        wr_ctrl(9'h000);
        ext_req_n = 1'b1;

        // R9 spare bit readback
        wr_ctrl(9'h017);
        chk(ctrl_rdata == 9'h017, "R9 spare readback", ctrl_rdata, 9'h017);
        wr_ctrl(9'h000);
        chk(ctrl_rdata[4] == 1'b0, "R9 spare cleared", ctrl_rdata[4], 0);

        // R5 edge mode with the spare bit set (R9 no effect)
        wr_cnt(16'd5); wr_dst(16'h0000);
        wr_ctrl({1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0010});
        bad = 0;
        repeat (6) begin @(negedge clk); if (bus_req) bad++; end
        chk(bad == 0, "R5 idle without edge", bad, 0);
        ext_req_n = 1'b0;
        xfer(seen);
        chk(seen, "R5 edge starts transfer", seen, 1);
        bad = 0;
        repeat (10) begin @(negedge clk); if (bus_req) bad++; end
        chk(bad == 0, "R5 one per edge", bad, 0);
        ext_req_n = 1'b1;
        repeat (4) @(negedge clk);
        ext_req_n = 1'b0;
        xfer(seen);
        chk(seen, "R5 second edge", seen, 1);
        chk(dst_addr == 16'h0002 && xfer_cnt == 16'd3, "R5 two transfers", dst_addr, 2);
        ext_req_n = 1'b1;
        wr_ctrl(9'h000);

        // R6 level mode
        wr_cnt(16'd10); wr_dst(16'h0040);
        wr_ctrl({1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0011});
        bad = 0;
        repeat (5) begin @(negedge clk); if (bus_req) bad++; end
        chk(bad == 0, "R6 idle while high", bad, 0);
        ext_req_n = 1'b0;
        xfer(seen);
        chk(seen, "R6 low starts", seen, 1);
        chk(bus_req == 1'b0, "R6 release after transfer", bus_req, 0);
        xfer(seen);
        chk(seen, "R6 re-request while low", seen, 1);
        @(negedge clk);
        ext_req_n = 1'b1;
        repeat (4) @(negedge clk);
        bad = 0;
        repeat (8) begin if (bus_req) bad++; @(negedge clk); end
        chk(bad == 0, "R6 stop after high", bad, 0);
        chk(xfer_cnt == 16'd8, "R6 count", xfer_cnt, 8);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule